// File: doc/BRIEF.md
# Frequency Synthesizer Divider and Lock Controller

This block is the digital half of a phase-locked clock generator. It runs on the VCO clock and divides it through a programmable feedback chain. The chain is a prescaler of 8 or 32 followed by a 6-bit down counter of modulus Y+1. The result is presented as a feedback pulse for the external phase comparator. A second path divides the VCO clock by two, or passes it straight through, to form the system clock. This postscaler sits outside the loop, so the VCO rate is unaffected by it.

A lock detector watches the reference clock. It samples the reference through a two-stage synchronizer and compares each reference rising edge with the feedback pulses. When 16 reference edges in a row each fall within a few VCO cycles of a feedback pulse, it raises a lock flag. A system reset output is held asserted from power-on until the flag first rises. A single 16-bit control register, readable and writable at any time, selects the divider settings and shows the lock flag. New divider settings are applied only at the end of a feedback period.

Top module: `clksynth_ctl`

## Requirements
- R1: While `por_n` is low and right after it is released, `rd_data` reads 16'h3F00 (Y=63, W=0, X=0), `locked` is 0 and `sys_rst_n` is 0.
- R2: The register layout is W at bit 15, X at bit 14 and Y at bits 13:8. The lock flag is at bit 3 and is read-only. Bits 7:4 and 2:0 read 0. A written W, X and Y are visible on `rd_data` in the cycle after the write.
- R3: `fb_clk` is a one-VCO-cycle high pulse. Its period is 8·(Y+1)·4^W VCO cycles for the active setting, and X has no effect on it.
- R4: With X=0 active, `sys_clk` toggles on every VCO rising edge. With X=1 active, `sys_clk` equals `vco_clk`.
- R5: A register write takes effect only at the next feedback terminal count. The feedback period in progress ends with the old setting.
- R6: A hit is a reference rising edge that, after synchronization, lies within TOL (default 4) VCO cycles of a feedback pulse. `locked` rises on the 16th consecutive hit, which is before the next feedback pulse.
- R7: A reference edge with no feedback pulse within the tolerance window is a miss. A miss clears `locked` and restarts the hit count.
- R8: A write whose W or Y differs from the stored value clears `locked` in the next cycle and restarts the hit count.
- R9: A write that changes only X leaves `locked` set.
- R10: `sys_rst_n` rises one cycle after `locked` first rises and never falls again until `por_n` is asserted, even when lock is later lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock; clocks all logic |
| por_n | input | 1 | Power-on reset, active low |
| ref_clk | input | 1 | Reference clock, sampled asynchronously |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| fb_clk | output | 1 | Feedback pulse, one per divider period |
| sys_clk | output | 1 | System clock, VCO/2 or VCO |
| locked | output | 1 | Lock flag |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
Register readback and the lock clear on a W or Y change are due one VCO cycle after the write edge. The bench therefore samples these at the first falling edge after the write. A new divider setting shows up only in the period that follows the next terminal count. For this reason, each period is measured between the second and third feedback pulses after a write. The bench also checks separately that the period in progress at the time of the write keeps its old length. The lock flag is due three cycles after the 16th following feedback pulse, so the bench counts feedback pulses up to the first high sample of the flag and expects exactly 16. The reset output is sampled one falling edge after that.

// File: rtl/clksynth_ctl.sv
module clksynth_ctl #(
  parameter int PRE_LO    = 8,
  parameter int PRE_HI    = 32,
  parameter int TOL       = 4,
  parameter int LOCK_HITS = 16
)(
  input  logic        vco_clk,
  input  logic        por_n,
  input  logic        ref_clk,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        fb_clk,
  output logic        sys_clk,
  output logic        locked,
  output logic        sys_rst_n
);
  localparam int PW = $clog2(PRE_HI);
  localparam int SW = $clog2(TOL + 2);
  localparam int HW = $clog2(LOCK_HITS);
  localparam logic [PW-1:0] PLO = PW'(PRE_LO - 1);
  localparam logic [PW-1:0] PHI = PW'(PRE_HI - 1);
  localparam logic [SW-1:0] TOLS = SW'(TOL);
  localparam logic [SW-1:0] SMAX = SW'(TOL + 1);
  localparam logic [HW-1:0] HLAST = HW'(LOCK_HITS - 1);

  logic          cw, cx, aw, ax;
  logic [5:0]    cy, ay, y_cnt;
  logic [PW-1:0] pre_cnt;
  logic          half, rst_done, pend;
  logic [2:0]    ref_q;
  logic [SW-1:0] since_fb, pcnt;
  logic [HW-1:0] hits;
  logic          unused_bits;

  assign unused_bits = ^wr_data[7:0];
  assign rd_data   = {cw, cx, cy, 4'b0000, locked, 3'b000};
  assign sys_clk   = ax ? vco_clk : half;
  assign sys_rst_n = rst_done;

  wire pre_end   = (pre_cnt == '0);
  wire term      = pre_end && (y_cnt == 6'd0);
  wire wy_change = wr_en && ((wr_data[15] != cw) || (wr_data[13:8] != cy));
  wire ref_edge  = ref_q[1] && !ref_q[2];
  wire near_fb   = fb_clk || (since_fb <= TOLS);
  wire ev_hit    = (ref_edge && near_fb) || (pend && fb_clk);
  wire ev_miss   = pend && !fb_clk && (pcnt == TOLS);

  always_ff @(posedge vco_clk or negedge por_n) begin
    if (!por_n) begin
      cw <= 1'b0; cx <= 1'b0; cy <= 6'h3F;
    end else if (wr_en) begin
      cw <= wr_data[15]; cx <= wr_data[14]; cy <= wr_data[13:8];
    end
  end

  always_ff @(posedge vco_clk or negedge por_n) begin
    if (!por_n) begin
      aw <= 1'b0; ax <= 1'b0; ay <= 6'h3F;
      pre_cnt <= PLO; y_cnt <= 6'h3F;
      fb_clk <= 1'b0; half <= 1'b0;
    end else begin
      fb_clk <= term;
      half   <= ~half;
      if (term) begin
        aw <= cw; ax <= cx; ay <= cy;
        pre_cnt <= cw ? PHI : PLO;
        y_cnt   <= cy;
      end else if (pre_end) begin
        pre_cnt <= aw ? PHI : PLO;
        y_cnt   <= y_cnt - 6'd1;
      end else begin
        pre_cnt <= pre_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge vco_clk or negedge por_n) begin
    if (!por_n) begin
      ref_q <= '0; since_fb <= SMAX;
    end else begin
      ref_q <= {ref_q[1:0], ref_clk};
      if (fb_clk)                since_fb <= '0;
      else if (since_fb != SMAX) since_fb <= since_fb + 1'b1;
    end
  end

  always_ff @(posedge vco_clk or negedge por_n) begin
    if (!por_n) begin
      locked <= 1'b0; hits <= '0; pend <= 1'b0; pcnt <= '0; rst_done <= 1'b0;
    end else begin
      rst_done <= rst_done | locked;
      if (wy_change) begin
        locked <= 1'b0; hits <= '0; pend <= 1'b0; pcnt <= '0;
      end else if (ev_hit) begin
        pend <= 1'b0;
        if (hits == HLAST) locked <= 1'b1;
        else               hits   <= hits + 1'b1;
      end else if (ev_miss) begin
        pend <= 1'b0; hits <= '0; locked <= 1'b0;
      end else if (ref_edge) begin
        pend <= 1'b1; pcnt <= '0;
      end else if (pend) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end
endmodule

module clksynth_ctl_chk (
  input logic        vco_clk,
  input logic        por_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        fb_clk,
  input logic        locked,
  input logic        sys_rst_n
);
  assert_wy_write_unlocks_R8: assert property (@(posedge vco_clk) disable iff (!por_n)
    wr_en && ((wr_data[15] != rd_data[15]) || (wr_data[13:8] != rd_data[13:8])) |=> !locked);

  assert_reg_readback_R2: assert property (@(posedge vco_clk) disable iff (!por_n)
    wr_en |=> rd_data[15:8] == $past(wr_data[15:8]));

  assert_spare_bits_zero_R2: assert property (@(posedge vco_clk) disable iff (!por_n)
    rd_data[7:4] == 4'b0000 && rd_data[2:0] == 3'b000 && rd_data[3] == locked);

  assert_fb_single_pulse_R3: assert property (@(posedge vco_clk) disable iff (!por_n)
    fb_clk |=> !fb_clk);

  assert_rst_sticky_R10: assert property (@(posedge vco_clk) disable iff (!por_n)
    !$fell(sys_rst_n));

  assert_rst_after_lock_R10: assert property (@(posedge vco_clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> $past(locked));
endmodule

bind clksynth_ctl clksynth_ctl_chk u_chk (
  .vco_clk(vco_clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .fb_clk(fb_clk), .locked(locked), .sys_rst_n(sys_rst_n)
);

// File: tb/tb_clksynth_ctl.sv
`timescale 1ns/1ps
module tb_clksynth_ctl;
  logic vco_clk = 1'b0;
  logic por_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic fb_clk, sys_clk, locked, sys_rst_n, ref_clk;

  int errors = 0, checks = 0;
  int dly = 0;
  logic [63:0] sh = '0;
  int tick = 0, npulse = 0, plast = 0, pprev = 0, lock_at = -1;
  bit lock_seen = 0;

  always #5 vco_clk = ~vco_clk;

  clksynth_ctl dut (
    .vco_clk(vco_clk), .por_n(por_n), .ref_clk(ref_clk), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .fb_clk(fb_clk), .sys_clk(sys_clk),
    .locked(locked), .sys_rst_n(sys_rst_n)
  );

  // reference model: a locked loop returns the feedback pulse, delayed by dly cycles
  assign ref_clk = |((sh >> dly) & 64'hF);

  always @(negedge vco_clk) begin
    sh   <= {sh[62:0], fb_clk};
    tick <= tick + 1;
    if (fb_clk) begin
      pprev  <= plast;
      plast  <= tick;
      npulse <= npulse + 1;
    end
    if (por_n && locked && !lock_seen) begin
      lock_seen <= 1'b1;
      lock_at   <= npulse;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge vco_clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge vco_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulses(input int k);
    int n0;
    n0 = npulse;
    wait (npulse >= n0 + k);
  endtask

  initial begin
    repeat (150000) @(posedge vco_clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0, s1, per, exp;
    // R1 reset state
    repeat (3) @(negedge vco_clk);
    chk(rd_data == 16'h3F00, "R1 rd_data in reset", rd_data, 16'h3F00);
    chk(locked == 1'b0, "R1 locked in reset", locked, 0);
    chk(sys_rst_n == 1'b0, "R1 sys_rst_n in reset", sys_rst_n, 0);
    por_n = 1'b1;
    @(negedge vco_clk);
    chk(rd_data == 16'h3F00, "R1 rd_data after release", rd_data, 16'h3F00);

    // R3 reset period, R6 lock after 16 hits, R10 reset release
    wait_pulses(2);
    chk(plast - pprev == 512, "R3 reset period", plast - pprev, 512);
    chk(sys_rst_n == 1'b0, "R10 held before lock", sys_rst_n, 0);
    wait (lock_seen);
    chk(lock_at == 16, "R6 pulses before lock", lock_at, 16);
    @(negedge vco_clk);
    chk(sys_rst_n == 1'b1, "R10 release after lock", sys_rst_n, 1);
    chk(rd_data == 16'h3F08, "R2 lock bit 3", rd_data, 16'h3F08);

    // R4 X=0: half rate
    for (int i = 0; i < 6; i++) begin
      @(negedge vco_clk); s0 = sys_clk;
      @(negedge vco_clk); s1 = sys_clk;
      chk(s0 != s1, "R4 toggles when X=0", s1, 1 - s0);
    end

    // R9 X-only write keeps lock
    wr(16'h7F00);
    chk(rd_data == 16'h7F08, "R2 readback X", rd_data, 16'h7F08);
    chk(locked == 1'b1, "R9 lock kept after X write", locked, 1);
    wait_pulses(3);
    chk(locked == 1'b1, "R9 lock kept over periods", locked, 1);
    chk(plast - pprev == 512, "R3 X leaves period", plast - pprev, 512);
    @(negedge vco_clk);
    chk(sys_clk == 1'b0, "R4 X=1 low phase", sys_clk, 0);
    @(posedge vco_clk); #2;
    chk(sys_clk == 1'b1, "R4 X=1 high phase", sys_clk, 1);

    // R8 Y change drops lock
    wr(16'h0300);
    chk(locked == 1'b0, "R8 lock cleared", locked, 0);
    chk(rd_data == 16'h0300, "R2 readback Y", rd_data, 16'h0300);
    wait_pulses(3);
    chk(locked == 1'b0, "R8 no early relock", locked, 0);
    wait_pulses(20);
    chk(locked == 1'b1, "R6 relock", locked, 1);

    // R7 miss, R10 sticky
    dly = 16;
    wait_pulses(3);
    chk(locked == 1'b0, "R7 miss clears lock", locked, 0);
    chk(sys_rst_n == 1'b1, "R10 stays released", sys_rst_n, 1);
    chk(rd_data[3] == 1'b0, "R2 lock bit follows", rd_data[3], 0);
    dly = 0;

    // R3 period sweep over W and Y
    for (int w = 0; w < 2; w++) begin
      foreach (s_list[j]) begin
        wr({w[0], 1'b0, s_list[j], 8'h00});
        wait_pulses(3);
        exp = 8 * (s_list[j] + 1) * (w == 1 ? 4 : 1);
        per = plast - pprev;
        chk(per == exp, $sformatf("R3 period W=%0d Y=%0d", w, s_list[j]), per, exp);
        @(negedge vco_clk);
        chk(fb_clk == 1'b0, "R3 pulse width", fb_clk, 0);
      end
    end

    // R5 write applies at terminal count only
    wr(16'hBF00);
    wait_pulses(2);
    repeat (100) @(negedge vco_clk);
    wr(16'h0000);
    wait_pulses(1);
    chk(plast - pprev == 2048, "R5 old period completes", plast - pprev, 2048);
    wait_pulses(1);
    chk(plast - pprev == 8, "R5 new period", plast - pprev, 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [5:0] s_list [8] = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd7, 6'd15, 6'd31, 6'd63};
endmodule